// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Unit

This unit watches a small general-purpose input port and raises an interrupt when an enabled pin's value changes. Each pin is set to one of two detection rules. In change mode the pin fires when its value differs from the previous sample, so rising and falling edges both count. In compare mode the pin fires for as long as its value differs from a programmed reference bit. The pins pass through a two-flop synchronizer before detection, and the synchronized value is the port register contents.

When a pin fires, the unit latches which pins caused the event and takes a snapshot of the port. Both stay frozen until software performs the clearing read. A configuration bit chooses whether that read is the port register or the capture register. The interrupt output can be active high or active low in push-pull mode, or it can act as an open-drain pull-down. The register interface sits outside this block and supplies only the register values and the read strobes.

Top module: `gpio_ioc_unit`

## Requirements
- R1: `port_o` equals the value `pin_i` had two clock edges earlier (two-flop synchronizer).
- R2: A pin whose `irq_en_i` bit is 0 never sets its `flag_o` bit and never starts an interrupt.
- R3: With its `cmp_mode_i` bit at 0, an enabled pin starts an interrupt when the synchronized value differs from the change reference. This covers both rising and falling edges. The reference tracks the port every cycle while no interrupt is pending and holds while one is pending.
- R4: With its `cmp_mode_i` bit at 1, an enabled pin starts an interrupt while the synchronized value differs from its `def_val_i` bit.
- R5: When an interrupt starts, `flag_o` holds the pins that fired and `cap_o` holds the port value of that cycle. Both stay unchanged until the clearing read.
- R6: With `cfg_i[0]` = 0, a `rd_port_i` pulse while pending clears the interrupt and `flag_o`. In this setting `rd_cap_i` has no effect.
- R7: With `cfg_i[0]` = 1, a `rd_cap_i` pulse while pending clears the interrupt and `flag_o`. In this setting `rd_port_i` has no effect.
- R8: If a compare-mode pin still differs from its default after the clearing read, the interrupt is pending again one cycle later.
- R9: In push-pull mode (`cfg_i[2]` = 0), `irq_oe_o` is 1. `irq_o` equals the pending state when `cfg_i[1]` = 1 and its inverse when `cfg_i[1]` = 0.
- R10: In open-drain mode (`cfg_i[2]` = 1), `irq_o` is 0 and `irq_oe_o` equals the pending state, whatever `cfg_i[1]` is.
- R11: After reset, `flag_o`, `cap_o` and `port_o` are 0 and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw pin levels |
| irq_en_i | input | 8 | Per-pin interrupt enable |
| def_val_i | input | 8 | Per-pin reference for compare mode |
| cmp_mode_i | input | 8 | Per-pin detection rule: 0 change, 1 compare |
| cfg_i | input | 3 | bit0 clear-by-capture-read, bit1 active high, bit2 open drain |
| rd_port_i | input | 1 | Port register read strobe |
| rd_cap_i | input | 1 | Capture register read strobe |
| port_o | output | 8 | Synchronized port value |
| flag_o | output | 8 | Pins that caused the pending interrupt |
| cap_o | output | 8 | Port snapshot taken at interrupt start |
| irq_o | output | 1 | Interrupt pad level |
| irq_oe_o | output | 1 | Interrupt pad output enable |

## Verification
A stale change reference shows at the ports as an interrupt that fires again right after a clearing read, or as an edge that is missed. Either appears in `flag_o` within one cycle of the clear. A pending bit that is stuck or cleared by the wrong strobe changes `irq_o` or `irq_oe_o` on the very next edge. A snapshot that is overwritten while pending shows in `cap_o` two cycles after the pin changes. The behavioural model is compared on every clock, so each of these faults is reported in the cycle it first reaches an output.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int CFG_W         = 3;
  localparam int CFG_CLR_CAP   = 0;
  localparam int CFG_ACT_HIGH  = 1;
  localparam int CFG_OPEN_DRN  = 2;

  typedef struct packed {
    logic lvl;
    logic oe;
  } pad_t;

  // Pad level and enable for a given pending state and output mode.
  function automatic pad_t ioc_pad(input logic active, input logic act_high,
                                   input logic open_drn);
    pad_t p;
    if (open_drn) begin
      p.lvl = 1'b0;
      p.oe  = active;
    end else begin
      p.lvl = act_high ? active : ~active;
      p.oe  = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/gpio_ioc_sync.sv
module gpio_ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ioc_detect.sv
module gpio_ioc_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic         hold_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] def_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] ref_o
);
  logic [W-1:0] ref_q;

  function automatic logic [W-1:0] pin_hits(input logic [W-1:0] en,
                                            input logic [W-1:0] cmp,
                                            input logic [W-1:0] dflt,
                                            input logic [W-1:0] cur,
                                            input logic [W-1:0] prev);
    logic [W-1:0] h;
    for (int b = 0; b < W; b++) begin
      h[b] = en[b] & (cmp[b] ? (cur[b] ^ dflt[b]) : (cur[b] ^ prev[b]));
    end
    return h;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_q <= '0;
    else if (!hold_i) ref_q <= cur_i;
  end

  assign hit_o = pin_hits(en_i, cmp_i, def_i, cur_i, ref_q);
  assign ref_o = ref_q;

  // Disabled pins never report a hit.
  assert_hit_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~en_i) == '0);
endmodule

// File: rtl/gpio_ioc_latch.sv
module gpio_ioc_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] snap_i,
  input  logic         clr_cap_sel_i,
  input  logic         rd_port_i,
  input  logic         rd_cap_i,
  output logic         pending_o,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] cap_o,
  output logic         set_evt_o,
  output logic         clr_evt_o
);
  logic         pending_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] cap_q;

  assign clr_evt_o = pending_q & (clr_cap_sel_i ? rd_cap_i : rd_port_i);
  assign set_evt_o = ~pending_q & (|hit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      flag_q    <= '0;
      cap_q     <= '0;
    end else if (clr_evt_o) begin
      pending_q <= 1'b0;
      flag_q    <= '0;
    end else if (set_evt_o) begin
      pending_q <= 1'b1;
      flag_q    <= hit_i;
      cap_q     <= snap_i;
    end
  end

  assign pending_o = pending_q;
  assign flag_o    = flag_q;
  assign cap_o     = cap_q;

  assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending_q) |-> (flag_q == $past(hit_i)) && (cap_q == $past(snap_i)));
  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !rd_port_i && !rd_cap_i |=> $stable(flag_q) && $stable(cap_q));
  assert_port_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !clr_cap_sel_i && rd_port_i |=> !pending_q && (flag_q == '0));
  assert_port_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && clr_cap_sel_i && !rd_cap_i |=> pending_q);
  assert_cap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && clr_cap_sel_i && rd_cap_i |=> !pending_q);
  assert_cap_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !clr_cap_sel_i && !rd_port_i |=> pending_q);
endmodule

// File: rtl/gpio_ioc_unit.sv
module gpio_ioc_unit
  import gpio_ioc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pin_i,
  input  logic [W-1:0]     irq_en_i,
  input  logic [W-1:0]     def_val_i,
  input  logic [W-1:0]     cmp_mode_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             rd_port_i,
  input  logic             rd_cap_i,
  output logic [W-1:0]     port_o,
  output logic [W-1:0]     flag_o,
  output logic [W-1:0]     cap_o,
  output logic             irq_o,
  output logic             irq_oe_o
);
  localparam int SYNC_STAGES = 2;

  logic [W-1:0] port_s;
  logic [W-1:0] hit_vec;
  logic [W-1:0] ref_vec;
  logic         pending;
  logic         set_evt;
  logic         clr_evt;
  pad_t         pad;

  gpio_ioc_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (port_s)
  );

  gpio_ioc_detect #(.W(W)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (port_s),
    .hold_i (pending),
    .en_i   (irq_en_i),
    .cmp_i  (cmp_mode_i),
    .def_i  (def_val_i),
    .hit_o  (hit_vec),
    .ref_o  (ref_vec)
  );

  gpio_ioc_latch #(.W(W)) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit_i         (hit_vec),
    .snap_i        (port_s),
    .clr_cap_sel_i (cfg_i[CFG_CLR_CAP]),
    .rd_port_i     (rd_port_i),
    .rd_cap_i      (rd_cap_i),
    .pending_o     (pending),
    .flag_o        (flag_o),
    .cap_o         (cap_o),
    .set_evt_o     (set_evt),
    .clr_evt_o     (clr_evt)
  );

  assign pad      = ioc_pad(pending, cfg_i[CFG_ACT_HIGH], cfg_i[CFG_OPEN_DRN]);
  assign irq_o    = pad.lvl;
  assign irq_oe_o = pad.oe;
  assign port_o   = port_s;

  // The change reference is held while an interrupt is pending.
  assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !clr_evt |=> $stable(ref_vec));
  assert_flag_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (flag_o & ~$past(irq_en_i)) == '0);
  assert_push_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i[CFG_OPEN_DRN] |-> irq_oe_o && (irq_o == (pending == cfg_i[CFG_ACT_HIGH])));
  assert_open_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i[CFG_OPEN_DRN] |-> !irq_o && (irq_oe_o == pending));
  assert_no_double_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_evt && clr_evt));
endmodule

// File: tb/gpio_ioc_unit_tb_top.sv
module gpio_ioc_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0, en = '0, dflt = '0, cmp = '0;
  logic [2:0] cfg = '0;
  logic       rdp = 1'b0, rdc = 1'b0;
  logic [7:0] port_o, flag_o, cap_o;
  logic       irq_o, irq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [7:0] pipe[$];
  logic [7:0] m_ref, m_flag, m_cap;
  bit         m_pend;

  always #10 clk = ~clk;

  gpio_ioc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .irq_en_i(en), .def_val_i(dflt),
    .cmp_mode_i(cmp), .cfg_i(cfg), .rd_port_i(rdp), .rd_cap_i(rdc),
    .port_o(port_o), .flag_o(flag_o), .cap_o(cap_o), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    pipe = {8'h00, 8'h00};
    m_ref = '0; m_flag = '0; m_cap = '0; m_pend = 1'b0;
  endtask

  task automatic compare_all();
    bit exp_o, exp_oe;
    if (cfg[2]) begin exp_o = 1'b0; exp_oe = m_pend; end
    else begin exp_o = cfg[1] ? m_pend : !m_pend; exp_oe = 1'b1; end
    chk("R1", "model port", port_o, pipe[0]);
    chk("R5", "model flag", flag_o, m_flag);
    chk("R5", "model cap", cap_o, m_cap);
    chk(cfg[2] ? "R10" : "R9", "model irq", {irq_o, irq_oe_o}, {exp_o, exp_oe});
  endtask

  // one clock: model next state from current inputs, advance, compare
  task automatic step();
    logic [7:0] cur, hits;
    bit clr;
    cur = pipe[0];
    for (int b = 0; b < 8; b++) begin
      int differs;
      differs = cmp[b] ? int'(cur[b] != dflt[b]) : int'(cur[b] != m_ref[b]);
      hits[b] = en[b] && (differs != 0);
    end
    clr = cfg[0] ? rdc : rdp;
    @(posedge clk);
    if (!m_pend) m_ref = cur;
    if (m_pend && clr) begin
      m_pend = 1'b0; m_flag = '0;
    end else if (!m_pend && hits != 0) begin
      m_pend = 1'b1; m_flag = hits; m_cap = cur;
    end
    pipe.push_back(pin);
    void'(pipe.pop_front());
    @(negedge clk);
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic read_port();
    rdp = 1'b1; step(); rdp = 1'b0;
  endtask

  task automatic read_cap();
    rdc = 1'b1; step(); rdc = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R11", "reset flag", flag_o, 0);
    chk("R11", "reset cap", cap_o, 0);
    chk("R11", "reset port", port_o, 0);
    chk("R11", "reset irq idle high", {irq_o, irq_oe_o}, 2'b11);
    rst_n = 1'b1;

    // R2: disabled pin changes do nothing
    pin = 8'h08; steps(4);
    chk("R2", "flag disabled", flag_o, 0);
    chk("R2", "irq idle", irq_o, 1);

    // R3 rising edge on bit0
    en = 8'h01; pin = 8'h09; steps(3);
    chk("R3", "rise flag", flag_o, 8'h01);
    chk("R3", "rise cap", cap_o, 8'h09);
    chk("R9", "active low asserted", irq_o, 0);

    // R5 frozen while pending
    pin = 8'h08; steps(3);
    chk("R5", "flag frozen", flag_o, 8'h01);
    chk("R5", "cap frozen", cap_o, 8'h09);
    chk("R1", "port follows", port_o, 8'h08);

    // R6 capture read ignored, port read clears
    read_cap();
    chk("R6", "cap read ignored", flag_o, 8'h01);
    read_port();
    chk("R6", "port read clears", flag_o, 0);
    chk("R6", "irq released", irq_o, 1);
    step();
    chk("R3", "fall flag", flag_o, 8'h01);
    chk("R3", "fall cap", cap_o, 8'h08);
    read_port(); steps(2);
    chk("R3", "quiet after clear", flag_o, 0);

    // R4 / R8 compare mode on bit4
    en = 8'h10; cmp = 8'h10; dflt = 8'h10; step();
    chk("R4", "compare flag", flag_o, 8'h10);
    chk("R4", "compare cap", cap_o, 8'h08);
    read_port();
    chk("R8", "cleared", flag_o, 0);
    step();
    chk("R8", "reasserted", flag_o, 8'h10);
    pin = 8'h18; steps(3); read_port(); steps(2);
    chk("R4", "match stays quiet", flag_o, 0);
    chk("R4", "irq idle", irq_o, 1);

    // R7 clear by capture read
    cfg = 3'b001; en = 8'h01; cmp = 8'h00; pin = 8'h19; steps(3);
    chk("R7", "flag set", flag_o, 8'h01);
    read_port();
    chk("R7", "port read ignored", flag_o, 8'h01);
    read_cap();
    chk("R7", "cap read clears", flag_o, 0);

    // R9 active high push-pull
    cfg = 3'b010; pin = 8'h18; steps(3);
    chk("R9", "active high asserted", {irq_o, irq_oe_o}, 2'b11);
    read_port(); step();
    chk("R9", "active high idle", {irq_o, irq_oe_o}, 2'b01);

    // R10 open drain, both polarities
    cfg = 3'b100; pin = 8'h19; steps(3);
    chk("R10", "od asserted", {irq_o, irq_oe_o}, 2'b01);
    read_port(); step();
    chk("R10", "od released", irq_oe_o, 0);
    cfg = 3'b110; pin = 8'h18; steps(3);
    chk("R10", "od ignores polarity", {irq_o, irq_oe_o}, 2'b01);
    read_port(); step();

    // R1 two-cycle synchronizer latency
    en = 8'h00; pin = 8'h5A; step();
    chk("R1", "one edge old", port_o, 8'h18);
    step();
    chk("R1", "two edges new", port_o, 8'h5A);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) pin = 8'($urandom);
      if ($urandom_range(0, 63) == 0) begin
        en = 8'($urandom); cmp = 8'($urandom); dflt = 8'($urandom);
        cfg = 3'($urandom);
      end
      rdp = ($urandom_range(0, 7) == 0);
      rdc = ($urandom_range(0, 7) == 0);
      step();
    end
    rdp = 1'b0; rdc = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule